// File: doc/BRIEF.md
# Dual-width Word Serializer

This block turns parallel transmission characters into a single-bit stream for a block-coded serial link. It runs from a fast bit clock. A bit-rate enable marks each bit time. A static mode input picks one of two word formats: one 10-bit character per word, or two 10-bit characters per word. Each word is taken from the parallel bus at a word boundary, placed in a shift register and sent one bit per enable, least significant bit of the selected field first.

Every word boundary raises a one-cycle word strobe, in the same cycle as the bit enable that takes the word. The upstream source uses the strobe to present its next word. A word-rate clock output toggles at every such load. The bit stream leaves on two outputs, a main line and a loopback line. Each has its own active-low enable, and a disabled output is driven low.

Top module: `word_serializer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears its state. After that edge `ser_out`, `loop_out` and `word_clk` are 0, and `word_tick` stays 0 for as long as `rst` is high.
- R2: `narrow_sel` = 1 selects 10-bit words; `narrow_sel` = 0 selects 20-bit words.
- R3: With 10-bit words, `din[9:0]` has no effect on either serial output.
- R4: With 10-bit words the bits go out in the order `din[10]`, `din[11]`, …, `din[19]`. With 20-bit words they go out in the order `din[0]`, `din[1]`, …, `din[19]`.
- R5: The serial bit changes only on a rising edge where `bit_en` is 1. It holds its value through cycles where `bit_en` is 0.
- R6: After reset, the first `bit_en` loads a word. Each later word loads on the `bit_en` that follows the last bit of the previous word, so there are no idle bits between words. `word_tick` is 1 in exactly the cycles where `bit_en` is 1 and a load takes place, and `din` is sampled at that edge.
- R7: `oe_main_n` and `oe_loop_n` are active-low enables for `ser_out` and `loop_out`, one each. A disabled output reads 0, and the enables act independently of each other.
- R8: `word_clk` toggles once at every word load and holds its value otherwise.
- R9: Between reset and the first load, both serial outputs read 0 whatever `din` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One bit time per high cycle |
| narrow_sel | input | 1 | 1 = 10-bit words, 0 = 20-bit words (static) |
| din | input | 20 | Parallel word, sampled when `word_tick` is high |
| oe_main_n | input | 1 | Active-low enable of `ser_out` |
| oe_loop_n | input | 1 | Active-low enable of `loop_out` |
| ser_out | output | 1 | Main serial data |
| loop_out | output | 1 | Loopback serial data |
| word_tick | output | 1 | Word load strobe (word-rate enable) |
| word_clk | output | 1 | Word-rate clock, toggles per load |

## Verification
The shift of the last bit of a word and the load of the next word fall on the same `bit_en` edge. This is the gapless boundary, and it is where an off-by-one would either repeat a bit or drop one. The bench provokes it with back-to-back words under a continuous enable and under a gappy enable, in both modes. At every enabled edge it compares the serial output with the bit it predicts from its own count of enables. It also requires `word_tick` exactly at each multiple of the word length, and the `word_clk` toggle at the same edge.

// File: rtl/ws_pkg.sv
package ws_pkg;
  parameter int unsigned CHAR_W = 10;
  parameter int unsigned NCHAR  = 2;
  localparam int unsigned WORD_W = CHAR_W * NCHAR;
  localparam int unsigned CNT_W  = $clog2(WORD_W);

  // Index of the final bit of a word in the selected mode.
  function automatic logic [CNT_W-1:0] last_index(input logic narrow);
    return narrow ? CNT_W'(CHAR_W - 1) : CNT_W'(WORD_W - 1);
  endfunction

  // Shift-register image of a word: the bit sent first lands in position 0.
  // In narrow mode only the topmost character field is taken.
  function automatic logic [WORD_W-1:0] load_image(input logic [WORD_W-1:0] d,
                                                   input logic narrow);
    return narrow ? (d >> (WORD_W - CHAR_W)) : d;
  endfunction
endpackage

// File: rtl/ws_bitcount.sv
module ws_bitcount
  import ws_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             narrow,
  output logic [CNT_W-1:0] cnt,
  output logic             valid,
  output logic             load
);
  logic at_last;

  always_comb begin
    at_last = valid && (cnt >= last_index(narrow));
    load    = bit_en && !rst && (!valid || at_last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      valid <= 1'b0;
    end else if (load) begin
      cnt   <= '0;
      valid <= 1'b1;
    end else if (bit_en) begin
      cnt   <= cnt + 1'b1;
    end
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> (cnt <= last_index(narrow)));
  // R6
  load_restart_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (valid && cnt == '0));
endmodule

// File: rtl/ws_shifter.sv
module ws_shifter
  import ws_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              bit_en,
  input  logic              narrow,
  input  logic [WORD_W-1:0] din,
  output logic              ser_bit
);
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst)         sreg <= '0;
    else if (load)   sreg <= load_image(din, narrow);
    else if (bit_en) sreg <= sreg >> 1;
  end

  assign ser_bit = sreg[0];

  // R5
  hold_no_en_chk: assert property (@(posedge clk) disable iff (rst)
    (!bit_en) |=> $stable(ser_bit));
endmodule

// File: rtl/ws_outgate.sv
module ws_outgate #(
  parameter int unsigned NLANE = 2
) (
  input  logic             ser_bit,
  input  logic [NLANE-1:0] oe_n,
  output logic [NLANE-1:0] lane
);
  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    assign lane[i] = ser_bit & ~oe_n[i];
  end
endmodule

// File: rtl/word_serializer.sv
module word_serializer
  import ws_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              narrow_sel,
  input  logic [WORD_W-1:0] din,
  input  logic              oe_main_n,
  input  logic              oe_loop_n,
  output logic              ser_out,
  output logic              loop_out,
  output logic              word_tick,
  output logic              word_clk
);
  localparam int unsigned NLANE = 2;

  logic [CNT_W-1:0] cnt;
  logic             valid;
  logic             load_evt;
  logic             ser_bit;
  logic [NLANE-1:0] lanes;

  ws_bitcount u_cnt (
    .clk(clk), .rst(rst), .bit_en(bit_en), .narrow(narrow_sel),
    .cnt(cnt), .valid(valid), .load(load_evt)
  );

  ws_shifter u_shf (
    .clk(clk), .rst(rst), .load(load_evt), .bit_en(bit_en),
    .narrow(narrow_sel), .din(din), .ser_bit(ser_bit)
  );

  ws_outgate #(.NLANE(NLANE)) u_out (
    .ser_bit(ser_bit), .oe_n({oe_loop_n, oe_main_n}), .lane(lanes)
  );

  assign ser_out   = lanes[0];
  assign loop_out  = lanes[1];
  assign word_tick = load_evt;

  always_ff @(posedge clk) begin
    if (rst)           word_clk <= 1'b0;
    else if (load_evt) word_clk <= ~word_clk;
  end

  // R8
  wclk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_evt) |=> $stable(word_clk));
  // R8
  wclk_flip_chk: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> (word_clk != $past(word_clk)));
  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid) |-> (!ser_out && !loop_out));
  // R7
  oe_main_chk: assert property (@(posedge clk) disable iff (rst)
    oe_main_n |-> !ser_out);
  // R7
  oe_loop_chk: assert property (@(posedge clk) disable iff (rst)
    oe_loop_n |-> !loop_out);
  // R6
  tick_gated_chk: assert property (@(posedge clk) disable iff (rst)
    word_tick |-> bit_en);
endmodule

// File: tb/test_word_serializer.sv
`timescale 1ns/1ps
module test_word_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic        narrow_sel = 1'b0;
  logic [19:0] din = '0;
  logic        oe_main_n = 1'b0;
  logic        oe_loop_n = 1'b0;
  logic        ser_out, loop_out, word_tick, word_clk;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  word_serializer i_word_serializer (
    .clk(clk), .rst(rst), .bit_en(bit_en), .narrow_sel(narrow_sel), .din(din),
    .oe_main_n(oe_main_n), .oe_loop_n(oe_loop_n), .ser_out(ser_out),
    .loop_out(loop_out), .word_tick(word_tick), .word_clk(word_clk)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [19:0] wgen(input int j, input int seed);
    logic [31:0] v;
    v = (32'(j) + 32'd1) * 32'h0005B3D1 ^ 32'(seed);
    return v[19:0];
  endfunction

  task automatic do_reset();
    rst = 1'b1; bit_en = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // R1 and R9: reset state and silence before the first load
  task automatic t_reset();
    rst = 1'b1; bit_en = 1'b1; din = 20'hFFFFF; oe_main_n = 0; oe_loop_n = 0;
    narrow_sel = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    check("R1 word_tick in reset", word_tick, 1'b0);
    @(posedge clk); #1;
    check("R1 ser_out", ser_out, 1'b0);
    check("R1 loop_out", loop_out, 1'b0);
    check("R1 word_clk", word_clk, 1'b0);
    rst = 1'b0; bit_en = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); #1;
      check("R9 ser_out before load", ser_out, 1'b0);
      check("R9 loop_out before load", loop_out, 1'b0);
      check("R8 word_clk idle", word_clk, 1'b0);
    end
  endtask

  // en_mode 1 = gappy enable; oe_mode 1 = enables alternate
  task automatic t_stream(input logic narrow, input bit en_mode, input bit oe_mode,
                          input int seed, input int nwords, input string tag);
    int   len, off, k, c;
    logic exp_bit, exp_wclk, en;
    logic [19:0] w;
    len = narrow ? 10 : 20;
    off = narrow ? 10 : 0;
    narrow_sel = narrow; oe_main_n = 0; oe_loop_n = 0;
    do_reset();
    k = 0; c = 0; exp_bit = 0; exp_wclk = 0;
    while (k < nwords * len) begin
      en = en_mode ? ((c % 3) != 1) : 1'b1;
      w  = wgen(k / len, seed);
      if (narrow) w[9:0] = 10'(c * 7) ^ 10'h2A5;  // R3: lower half churns
      din = w; bit_en = en;
      if (oe_mode) begin
        oe_main_n = c[2];
        oe_loop_n = ~c[2];
      end
      @(negedge clk);
      check({tag, " R6 word_tick"}, word_tick, en && (k % len == 0));
      @(posedge clk); #1;
      if (en) begin
        w = wgen(k / len, seed);
        exp_bit = w[(k % len) + off];
        if (k % len == 0) exp_wclk = ~exp_wclk;
        k++;
      end
      check({tag, " R4 R5 ser_out"}, ser_out, exp_bit & ~oe_main_n);
      check({tag, " R7 loop_out"}, loop_out, exp_bit & ~oe_loop_n);
      check({tag, " R8 word_clk"}, word_clk, exp_wclk);
      c++;
    end
    bit_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_stream(1'b0, 1'b0, 1'b0, 32'h11, 5, "R2 wide");
    t_stream(1'b1, 1'b0, 1'b0, 32'h2F, 6, "R2 R3 narrow");
    t_stream(1'b0, 1'b1, 1'b0, 32'h47, 4, "R5 wide gappy");
    t_stream(1'b1, 1'b1, 1'b1, 32'h5C, 6, "R7 narrow gappy oe");
    t_stream(1'b0, 1'b0, 1'b1, 32'h63, 3, "R7 wide oe");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule